// File: doc/BRIEF.md
# 16-bit Gated/Compare Peripheral Timer

This block is a 16-bit up-counting timer with two operating modes. It is set up through a small byte-wide register file. In compare mode it counts prescaled system-clock ticks and raises an interrupt when the count lands on a programmed compare value. It does not reload at that point and keeps counting, wrapping from 0xFFFF to 0x0000. In gated mode it counts prescaled ticks only while a synchronized external input is at the level chosen in the control register. When the count reaches the programmed reload value it restarts at 0x0001. It also interrupts when the input leaves its active level.

Software writes the control register with the enable bit clear. It then loads the starting count and the compare/reload value one byte at a time, and finally sets the enable bit. Each compare match or reload toggles an output level. That output is visible on a pin when the output function is enabled. The compare interval is (compare value − start value) × prescale divider system-clock periods.

Top module: `timer16_gcmp`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, `irq` is 0 and `tmr_out` is 0.
- R2: Register addresses are: 0 control, 1 count high byte, 2 count low byte, 3 reload high byte, 4 reload low byte. Any other address reads 0x00. Control bits are: [0] enable, [1] mode (0 compare, 1 gated), [2] active input level, [3] output enable, [4] initial output level, [7:5] prescale exponent. Reads are combinational on `reg_addr`.
- R3: The prescaler divides by 2^exponent (1 to 128) and yields one count tick every divider period while the timer runs. It is cleared while the timer is disabled.
- R4: In compare mode the count advances on every tick, whatever the level of `tmr_in`, and rolls from 0xFFFF to 0x0000.
- R5: In compare mode, a tick that makes the count equal to the compare value raises the interrupt and toggles the output level; the count is not reset.
- R6: In gated mode ticks occur only while `tmr_in`, after a two-flop synchronizer, equals the active-level bit.
- R7: In gated mode, a tick that would make the count equal to the reload value sets the count to 0x0001, raises the interrupt and toggles the output level.
- R8: In gated mode while enabled, a change of the synchronized input from its active to its inactive level raises the interrupt.
- R9: `tmr_out` shows the output level when output enable is 1 and is 0 otherwise. A control write with enable 0 loads the output level from the initial-level bit.
- R10: A count-byte write in the same cycle as a tick wins: the written byte is stored, the other byte keeps its value, and that tick raises no interrupt and no toggle.
- R11: `irq` is registered: it is high for the one cycle after the clock edge on which an interrupt event occurred.
- R12: While disabled the count holds (except for register writes) and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tmr_in | input | 1 | Asynchronous timer gate input |
| tmr_out | output | 1 | Timer output level |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two functions can fall in the same cycle. The first pair is the compare match and the 0xFFFF-to-0x0000 rollover: a compare value of 0x0000 makes both happen on one tick, and exactly one interrupt with one output toggle is expected. The second pair is a software count write and a counter tick. The bench writes the low count byte on every cycle with a divider of 1. It then expects the written value to hold and no interrupt to appear. After the writes stop, the match must arrive at the predicted count. A behavioural reference model, kept apart from the RTL, predicts `irq`, `tmr_out` and the register read data on every clock. Random gate patterns in gated mode drive the reload path and the deassertion path together.

// File: rtl/timer16_pkg.sv
package timer16_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int PS_W   = 3;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_RLD_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_RLD_LO = 3'd4;

    typedef enum logic {
        MODE_CMP  = 1'b0,
        MODE_GATE = 1'b1
    } tmode_e;

    // Control byte, MSB first
    typedef struct packed {
        logic [PS_W-1:0] pscale;
        logic            out_init;
        logic            out_en;
        logic            pol;
        tmode_e          mode;
        logic            en;
    } ctrl_t;

    // Terminal value of the prescale accumulator for a given exponent
    function automatic logic [(1<<PS_W)-2:0] pre_limit(input logic [PS_W-1:0] sel);
        logic [(1<<PS_W)-2:0] ones;
        ones = '1;
        return ~(ones << sel);
    endfunction

endpackage

// File: rtl/timer16_sync.sv
module timer16_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic dout_prev
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain     <= '0;
            dout_prev <= 1'b0;
        end else begin
            chain     <= {chain[STAGES-2:0], din};
            dout_prev <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];

    // R6: the synchronized level is the raw input delayed by exactly STAGES edges
    generate
        if (STAGES == 2) begin : g_chk2
            assert_sync_delay_R6: assert property (@(posedge clk) disable iff (rst)
                !$isunknown($past(din, 2)) |-> dout == $past(din, 2) || $past(rst, 2) || $past(rst));
        end
    endgenerate

endmodule

// File: rtl/timer16_prescale.sv
module timer16_prescale
    import timer16_pkg::*;
#(
    parameter int SEL_W = PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int ACC_W = (1 << SEL_W) - 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] limit;

    always_comb begin
        limit = pre_limit(sel);
        tick  = adv && !clear && (acc >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (adv) begin
            acc <= tick ? '0 : acc + 1'b1;
        end
    end

    // R3: a running prescaler steps by one until its tick
    assert_pre_step_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !clear && !tick) |=> acc == $past(acc) + 1'b1);

    // R3: disabled means empty prescaler on the next cycle
    assert_pre_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc == '0);

endmodule

// File: rtl/timer16_count.sv
module timer16_count
    import timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  tmode_e            mode,
    input  logic              gate_fell,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  reload,
    input  logic              out_load,
    input  logic              out_init,
    output logic [CNT_W-1:0]  count,
    output logic              out_state,
    output logic              irq
);

    logic [CNT_W-1:0] nxt;
    logic             hit;
    logic             cnt_wr;
    logic             evt;

    always_comb begin
        nxt    = count + 1'b1;
        hit    = tick && (nxt == reload);
        cnt_wr = wr_hi || wr_lo;
        evt    = hit && !cnt_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            out_state <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= evt || gate_fell;
            if (cnt_wr) begin
                count <= {wr_hi ? wdata : count[CNT_W-1:BYTE_W],
                          wr_lo ? wdata : count[BYTE_W-1:0]};
            end else if (tick) begin
                count <= (hit && mode == MODE_GATE) ? CNT_W'(1) : nxt;
            end
            if (out_load) begin
                out_state <= out_init;
            end else if (evt) begin
                out_state <= ~out_state;
            end
        end
    end

    // R4: compare mode never reloads, it only steps (with wrap)
    assert_cmp_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MODE_CMP && !cnt_wr) |=> count == $past(count) + 1'b1);

    // R7: a gated reload lands on one
    assert_gate_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (evt && mode == MODE_GATE) |=> count == CNT_W'(1));

    // R9: output level moves only on an event or a disabling control write
    assert_out_cause_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_state) |-> $past(evt || out_load));

    // R10: a written low byte is what the counter holds next
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> count[BYTE_W-1:0] == $past(wdata));

endmodule

// File: rtl/timer16_gcmp.sv
module timer16_gcmp
    import timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              tmr_in,
    output logic              tmr_out,
    output logic              irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             in_sync;
    logic             in_prev;
    logic             gate_act;
    logic             run;
    logic             gate_fell;
    logic             tick;
    logic             out_state;
    logic             wr_ctrl;
    logic             wr_cnt_hi;
    logic             wr_cnt_lo;

    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == ADR_CTRL);
        wr_cnt_hi = reg_wr && (reg_addr == ADR_CNT_HI);
        wr_cnt_lo = reg_wr && (reg_addr == ADR_CNT_LO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_CTRL:   ctrl                   <= ctrl_t'(reg_wdata);
                ADR_RLD_HI: reload[CNT_W-1:BYTE_W] <= reg_wdata;
                ADR_RLD_LO: reload[BYTE_W-1:0]     <= reg_wdata;
                default:    ;
            endcase
        end
    end

    timer16_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .din       (tmr_in),
        .dout      (in_sync),
        .dout_prev (in_prev)
    );

    always_comb begin
        gate_act  = (ctrl.mode == MODE_GATE) ? (in_sync == ctrl.pol) : 1'b1;
        run       = ctrl.en && gate_act;
        gate_fell = ctrl.en && (ctrl.mode == MODE_GATE)
                    && (in_prev == ctrl.pol) && (in_sync != ctrl.pol);
    end

    timer16_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (!ctrl.en),
        .adv   (run),
        .sel   (ctrl.pscale),
        .tick  (tick)
    );

    timer16_count u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (ctrl.mode),
        .gate_fell (gate_fell),
        .wr_hi     (wr_cnt_hi),
        .wr_lo     (wr_cnt_lo),
        .wdata     (reg_wdata),
        .reload    (reload),
        .out_load  (wr_ctrl && !reg_wdata[0]),
        .out_init  (reg_wdata[4]),
        .count     (count),
        .out_state (out_state),
        .irq       (irq)
    );

    always_comb begin
        case (reg_addr)
            ADR_CTRL:   reg_rdata = ctrl;
            ADR_CNT_HI: reg_rdata = count[CNT_W-1:BYTE_W];
            ADR_CNT_LO: reg_rdata = count[BYTE_W-1:0];
            ADR_RLD_HI: reg_rdata = reload[CNT_W-1:BYTE_W];
            ADR_RLD_LO: reg_rdata = reload[BYTE_W-1:0];
            default:    reg_rdata = '0;
        endcase
        tmr_out = ctrl.out_en && out_state;
    end

    // R11: an interrupt pulse follows a cycle in which the timer was enabled
    assert_irq_enabled_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctrl.en));

    // R12: a disabled timer with no count write keeps its count
    assert_hold_disabled_R12: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !wr_cnt_hi && !wr_cnt_lo) |=> $stable(count));

    // R6: in gated mode no tick while the gate is inactive
    assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_GATE && in_sync != ctrl.pol) |-> !tick);

endmodule

// File: tb/timer16_gcmp_test.sv
`timescale 1ns/1ps
module timer16_gcmp_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd2;
    logic [7:0] wdata = 8'h00;
    logic       tin = 1'b0;
    logic [7:0] rdata;
    logic       tout;
    logic       irq;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    started = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    timer16_gcmp uut (
        .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .tmr_in(tin), .tmr_out(tout), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0]  m_ctrl;
    logic [15:0] m_cnt, m_rld;
    logic        m_out, m_irq, m_s1, m_s2, m_s3;
    int          m_pre;

    always @(posedge clk) begin : model
        logic en, gm, pol, gate, run, tick, fell, hit, ev, cw;
        logic [15:0] nx;
        int lim;
        cyc++;
        started = 1;
        if (rst) begin
            m_ctrl = 0; m_cnt = 0; m_rld = 0; m_out = 0; m_irq = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0;
        end else begin
            en   = m_ctrl[0];
            gm   = m_ctrl[1];
            pol  = m_ctrl[2];
            lim  = (1 << m_ctrl[7:5]) - 1;
            gate = gm ? (m_s2 == pol) : 1'b1;
            run  = en && gate;
            tick = run && (m_pre >= lim);
            fell = en && gm && (m_s3 == pol) && (m_s2 != pol);
            nx   = m_cnt + 16'd1;
            hit  = tick && (nx == m_rld);
            cw   = wr && (addr == 3'd1 || addr == 3'd2);
            ev   = hit && !cw;
            m_irq = ev || fell;
            if (!en) m_pre = 0;
            else if (run) m_pre = tick ? 0 : m_pre + 1;
            if (cw) begin
                if (addr == 3'd1) m_cnt[15:8] = wdata;
                else m_cnt[7:0] = wdata;
            end else if (tick) begin
                m_cnt = (hit && gm) ? 16'd1 : nx;
            end
            if (wr && addr == 3'd0 && !wdata[0]) m_out = wdata[4];
            else if (ev) m_out = ~m_out;
            if (wr) begin
                case (addr)
                    3'd0: m_ctrl = wdata;
                    3'd3: m_rld[15:8] = wdata;
                    3'd4: m_rld[7:0] = wdata;
                    default: ;
                endcase
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = tin;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_cnt[15:8];
            3'd2: return m_cnt[7:0];
            3'd3: return m_rld[15:8];
            3'd4: return m_rld[7:0];
            default: return 8'h00;
        endcase
    endfunction

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #1;
        if (started) begin
            chk(irq === m_irq, phase, "irq vs model", irq, m_irq);
            chk(tout === (m_ctrl[3] && m_out), phase, "tmr_out vs model", tout, m_ctrl[3] && m_out);
            chk(rdata === exp_rd(addr), phase, "rdata vs model", rdata, exp_rd(addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; addr = 3'd2;
    endtask

    task automatic cfg(input logic [7:0] c, input logic [15:0] start, input logic [15:0] rld);
        wreg(3'd0, c & 8'hFE);
        wreg(3'd1, start[15:8]);
        wreg(3'd2, start[7:0]);
        wreg(3'd3, rld[15:8]);
        wreg(3'd4, rld[7:0]);
        wreg(3'd0, c | 8'h01);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1 v = rdata; addr = 3'd2;
    endtask

    task automatic count_irq(input int n, output int k);
        k = 0;
        repeat (n) begin
            @(posedge clk); #1;
            if (irq) k++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 5);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] v, a0, b0;
        int k, t0, t1;
        bit bad, prev_irq;
        logic [15:0] lfsr;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        phase = "R1";
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v);
            chk(v == 8'h00, "R1", "register after reset", v, 0);
        end
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        chk(tout == 1'b0, "R1", "tmr_out after reset", tout, 0);

        // R2 register map and readback
        phase = "R2";
        wreg(3'd3, 8'hA5);
        wreg(3'd4, 8'h3C);
        rd(3'd3, v); chk(v == 8'hA5, "R2", "reload hi readback", v, 8'hA5);
        rd(3'd4, v); chk(v == 8'h3C, "R2", "reload lo readback", v, 8'h3C);
        wreg(3'd0, 8'hE6);
        rd(3'd0, v); chk(v == 8'hE6, "R2", "control readback", v, 8'hE6);
        rd(3'd6, v); chk(v == 8'h00, "R2", "unmapped address", v, 0);

        // R4/R5 compare mode, input toggling has no effect
        phase = "R5";
        cfg(8'h18, 16'hFFFA, 16'hFFFD);
        k = 0; bad = 0; prev_irq = 0;
        repeat (20) begin
            @(negedge clk); tin = ~tin;
            @(posedge clk); #1;
            if (irq) k++;
            if (irq && prev_irq) bad = 1;
            prev_irq = irq;
        end
        chk(k == 1, "R5", "one compare interrupt", k, 1);
        chk(!bad, "R11", "irq wider than one cycle", bad, 0);
        chk(tout == 1'b0, "R5", "output toggled from initial 1", tout, 0);
        phase = "R4";
        @(posedge clk); #1 a0 = rdata;
        @(posedge clk); #1 b0 = rdata;
        chk(b0 == a0 + 8'd1, "R4", "count steps every cycle", b0, a0 + 8'd1);

        // R4 match coinciding with rollover (compare value 0)
        cfg(8'h58, 16'hFFFC, 16'h0000);
        count_irq(30, k);
        chk(k == 1, "R4", "match at wrap gives one interrupt", k, 1);

        // R3 prescale by 8
        phase = "R3";
        cfg(8'h78, 16'h0000, 16'h8000);
        @(posedge clk); #1 a0 = rdata;
        for (int i = 0; i < 40 && rdata == a0; i++) begin @(posedge clk); #1; end
        t0 = cyc; a0 = rdata;
        for (int i = 0; i < 40 && rdata == a0; i++) begin @(posedge clk); #1; end
        t1 = cyc;
        chk(t1 - t0 == 8, "R3", "cycles per tick at exponent 3", t1 - t0, 8);

        // R6 gated, gate inactive then active; R8 deassert interrupt
        phase = "R6";
        tin = 1'b0;
        cfg(8'h0E, 16'h0000, 16'h1000);
        repeat (10) @(posedge clk);
        rd(3'd2, v); chk(v == 8'h00, "R6", "no count while gate inactive", v, 0);
        @(negedge clk); tin = 1'b1;
        repeat (20) @(posedge clk);
        rd(3'd2, v); chk(v != 8'h00, "R6", "count moves while gate active", v, 1);
        phase = "R8";
        @(negedge clk); tin = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk(irq == 1'b0, "R8", "no interrupt before synchronizer delay", irq, 0);
        @(posedge clk); #1;
        chk(irq == 1'b1, "R8", "interrupt on gate deassert", irq, 1);
        rd(3'd2, a0);
        repeat (5) @(posedge clk);
        rd(3'd2, b0);
        chk(a0 == b0, "R6", "count holds after gate drops", b0, a0);

        // R7 gated reload to 0x0001
        phase = "R7";
        tin = 1'b1;
        cfg(8'h0E, 16'h0000, 16'h0005);
        k = 0; bad = 0;
        repeat (6) @(posedge clk);
        repeat (30) begin
            @(posedge clk); #1;
            if (irq) k++;
            if (rdata == 8'd0 || rdata > 8'd4) bad = 1;
        end
        chk(!bad, "R7", "count stays within 1..4", bad, 0);
        chk(k >= 6, "R7", "reload interrupts seen", k, 6);

        // R8/R6 random gate, active-low, prescale 2
        phase = "R8";
        cfg(8'h2A, 16'h0000, 16'h0007);
        lfsr = 16'hACE1; k = 0;
        repeat (400) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0) tin = ~tin;
            @(posedge clk); #1;
            if (irq) k++;
        end
        chk(k > 0, "R8", "random gate produced interrupts", k, 1);

        // R10 count write colliding with ticks
        phase = "R10";
        cfg(8'h18, 16'h0000, 16'h0010);
        k = 0;
        @(negedge clk); wr = 1'b1; addr = 3'd2; wdata = 8'h05;
        repeat (30) begin
            @(posedge clk); #1;
            if (irq) k++;
        end
        chk(k == 0, "R10", "no interrupt while write wins", k, 0);
        chk(rdata == 8'h05, "R10", "written byte held", rdata, 5);
        @(negedge clk); wr = 1'b0;
        count_irq(15, k);
        chk(k == 1, "R10", "match after writes stop", k, 1);

        // R12 disabled hold, R9 output load and enable
        phase = "R12";
        wreg(3'd0, 8'h18);
        #1 chk(tout == 1'b1, "R9", "disable write loads initial level", tout, 1);
        rd(3'd2, a0);
        count_irq(10, k);
        rd(3'd2, b0);
        chk(k == 0, "R12", "no interrupt while disabled", k, 0);
        chk(a0 == b0, "R12", "count holds while disabled", b0, a0);
        phase = "R9";
        wreg(3'd0, 8'h10);
        #1 chk(tout == 1'b0, "R9", "output disabled forces 0", tout, 0);

        repeat (3) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule